// File: doc/BRIEF.md
# Poison-Tagged Register File with Speculative Load Check

This block is a general register file in which every entry carries one extra bit: a poison tag that records a memory fault held back for later. Completed loads, arithmetic results and immediate moves all write through it. An ordinary load that faults does not write its destination and raises an exception pulse instead. A speculative load that faults raises nothing and sets the poison tag on its destination, so code can issue the load early, above the branch that used to guard it.

Poison spreads through dependent arithmetic: a sum is tagged when either operand is tagged. A check operation names one register and carries a recovery address. When that register is poisoned, the block emits a one-cycle redirect pulse with the recovery address. When it is clean, the check does nothing and the instruction stream continues. The memory system and the recovery code lie outside the block. It accepts one operation per cycle through a small operation port and has one combinational read port for observing architectural state.

Top module: `deferred_tag_rf`

## Requirements
- R1: After reset every register reads zero with a clear tag, and `excValid` and `redirectValid` are low.
- R2: A move (opKind 5) or a non-faulting ordinary load (opKind 1) writes `opData` to `opDest` and clears its tag, and the new value is visible on the read port right after the clock edge.
- R3: A speculative load (opKind 2) with `loadFault` high never raises `excValid`. It writes zero data to `opDest` and sets its tag.
- R4: A speculative load with `loadFault` low writes `opData` and clears the destination tag.
- R5: An ordinary load with `loadFault` high raises `excValid` for exactly the cycle after the operation and leaves the destination's data and tag unchanged.
- R6: An add (opKind 3) writes `opSrcA + opSrcB` modulo 2^DATA_W to `opDest`, tagged with the OR of the two source tags.
- R7: A check (opKind 4) on a register whose tag is set drives `redirectValid` high for the single following cycle, with `redirectTarget` equal to the check's `opData`. It changes no register.
- R8: A check on a register whose tag is clear produces no redirect and changes no register.
- R9: Register 0 always reads zero with a clear tag. Writes to it are dropped, and a check on it never redirects.
- R10: While `opValid` is low, no register changes and no exception or redirect pulse follows, whatever the other operation inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 3 | 0 none, 1 load, 2 speculative load, 3 add, 4 check, 5 move |
| opDest | input | ADDR_W | Destination register |
| opSrcA | input | ADDR_W | First source register, also the register a check examines |
| opSrcB | input | ADDR_W | Second source register of an add |
| opData | input | DATA_W | Load data, move immediate, or check recovery address |
| loadFault | input | 1 | Memory reported a fault for this load |
| rdAddr | input | ADDR_W | Observation read address |
| rdData | output | DATA_W | Data of register rdAddr |
| rdTag | output | 1 | Poison tag of register rdAddr |
| excValid | output | 1 | One-cycle pulse: an ordinary load faulted |
| redirectValid | output | 1 | One-cycle pulse: a check found poison |
| redirectTarget | output | DATA_W | Recovery address, valid with redirectValid |

## Verification
The assertions take for granted that `opKind` only carries the six listed codes and that `loadFault` only matters for the two load kinds. The stimulus uses only those codes and raises `loadFault` on moves, adds or checks nowhere. The properties on the pulses look one cycle into the past. This is sound because the pulse registers are reset together with the register file, so the reset cycle itself reads as an idle operation. The bench changes the inputs only at falling edges, so each operation is seen by exactly one rising edge.

// File: rtl/dtag_pkg.sv
`timescale 1ns/1ps
package dtag_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_LOAD      = 3'd1,
    OP_LOAD_SPEC = 3'd2,
    OP_ADD       = 3'd3,
    OP_CHECK     = 3'd4,
    OP_MOVE      = 3'd5
  } opKind_e;

  typedef enum logic [1:0] {
    TAG_CLEAR = 2'd0,
    TAG_SET   = 2'd1,
    TAG_MERGE = 2'd2
  } tagSrc_e;

  typedef enum logic {
    DATA_EXT = 1'b0,
    DATA_SUM = 1'b1
  } dataSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     wrEn;
    dataSrc_e dataSrc;
    tagSrc_e  tagSrc;
    logic     zeroData;
    logic     chkEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/dtag_control.sv
`timescale 1ns/1ps
module dtag_control
  import dtag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [2:0]   opKind,
  input  logic         loadFault,
  input  logic         chkTag,
  output ctrlStrobes_t strobes,
  output logic         excValid,
  output logic         redirectValid
);

  opKind_e kind;
  logic    raiseExc;

  assign kind = opKind_e'(opKind);

  always_comb begin
    strobes  = '{wrEn: 1'b0, dataSrc: DATA_EXT, tagSrc: TAG_CLEAR,
                 zeroData: 1'b0, chkEn: 1'b0};
    raiseExc = 1'b0;
    if (opValid) begin
      unique case (kind)
        OP_LOAD: begin
          // faulting ordinary load: signal now, keep destination
          if (loadFault) raiseExc = 1'b1;
          else           strobes.wrEn = 1'b1;
        end
        OP_LOAD_SPEC: begin
          // faulting speculative load: defer by poisoning destination
          strobes.wrEn     = 1'b1;
          strobes.tagSrc   = loadFault ? TAG_SET : TAG_CLEAR;
          strobes.zeroData = loadFault;
        end
        OP_ADD: begin
          strobes.wrEn    = 1'b1;
          strobes.dataSrc = DATA_SUM;
          strobes.tagSrc  = TAG_MERGE;
        end
        OP_CHECK: strobes.chkEn = 1'b1;
        OP_MOVE:  strobes.wrEn  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid      <= 1'b0;
      redirectValid <= 1'b0;
    end else begin
      excValid      <= raiseExc;
      redirectValid <= strobes.chkEn & chkTag;
    end
  end

endmodule

// File: rtl/dtag_datapath.sv
`timescale 1ns/1ps
module dtag_datapath
  import dtag_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] opDest,
  input  logic [ADDR_W-1:0] opSrcA,
  input  logic [ADDR_W-1:0] opSrcB,
  input  logic [DATA_W-1:0] opData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdTag,
  output logic              srcTagA,
  output logic [DATA_W-1:0] redirectTarget
);

  logic [DATA_W-1:0] regData [NUM_REGS];
  logic              regTag  [NUM_REGS];

  logic [DATA_W-1:0] srcDataA, srcDataB, sumData, wrData;
  logic              srcTagB, wrTag;

  assign srcDataA = regData[opSrcA];
  assign srcDataB = regData[opSrcB];
  assign srcTagA  = regTag[opSrcA];
  assign srcTagB  = regTag[opSrcB];
  assign sumData  = srcDataA + srcDataB;

  always_comb begin
    if (strobes.zeroData)                wrData = '0;
    else if (strobes.dataSrc == DATA_SUM) wrData = sumData;
    else                                 wrData = opData;
    unique case (strobes.tagSrc)
      TAG_SET:   wrTag = 1'b1;
      TAG_MERGE: wrTag = srcTagA | srcTagB;
      default:   wrTag = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    if (g == 0) begin : gZero
      assign regData[g] = '0;
      assign regTag[g]  = 1'b0;
    end else begin : gLive
      logic [DATA_W-1:0] dataQ;
      logic              tagQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dataQ <= '0;
          tagQ  <= 1'b0;
        end else if (strobes.wrEn && opDest == ADDR_W'(g)) begin
          dataQ <= wrData;
          tagQ  <= wrTag;
        end
      end
      assign regData[g] = dataQ;
      assign regTag[g]  = tagQ;
    end
  end

  assign rdData = regData[rdAddr];
  assign rdTag  = regTag[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          redirectTarget <= '0;
    else if (strobes.chkEn && srcTagA)  redirectTarget <= opData;
  end

endmodule

// File: rtl/deferred_tag_rf.sv
`timescale 1ns/1ps
module deferred_tag_rf
  import dtag_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [ADDR_W-1:0] opDest,
  input  logic [ADDR_W-1:0] opSrcA,
  input  logic [ADDR_W-1:0] opSrcB,
  input  logic [DATA_W-1:0] opData,
  input  logic              loadFault,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdTag,
  output logic              excValid,
  output logic              redirectValid,
  output logic [DATA_W-1:0] redirectTarget
);

  ctrlStrobes_t strobes;
  logic         srcTagA;

  dtag_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .opValid      (opValid),
    .opKind       (opKind),
    .loadFault    (loadFault),
    .chkTag       (srcTagA),
    .strobes      (strobes),
    .excValid     (excValid),
    .redirectValid(redirectValid)
  );

  dtag_datapath #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .opDest        (opDest),
    .opSrcA        (opSrcA),
    .opSrcB        (opSrcB),
    .opData        (opData),
    .rdAddr        (rdAddr),
    .rdData        (rdData),
    .rdTag         (rdTag),
    .srcTagA       (srcTagA),
    .redirectTarget(redirectTarget)
  );

endmodule

// File: rtl/dtag_checker.sv
`timescale 1ns/1ps
module dtag_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opKind,
  input logic [DATA_W-1:0] opData,
  input logic              loadFault,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              rdTag,
  input logic              excValid,
  input logic              redirectValid,
  input logic [DATA_W-1:0] redirectTarget,
  input logic              srcTagA
);

  // R5: an exception pulse only follows a faulting ordinary load
  a_r5_exc_cause: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(opValid && opKind == 3'd1 && loadFault));

  // R3: a speculative load never raises the exception pulse
  a_r3_spec_silent: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd2) |=> !excValid);

  // R7: a redirect only follows a check of a poisoned register
  a_r7_redirect_cause: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(opValid && opKind == 3'd4 && srcTagA));

  // R7: the redirect carries the check's recovery address
  a_r7_redirect_target: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> redirectTarget == $past(opData));

  // R8: a check of a clean register never redirects
  a_r8_clean_check: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd4 && !srcTagA) |=> !redirectValid);

  // R9: register 0 reads as a clean zero
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == '0) |-> (rdData == '0 && !rdTag));

  // R10: an idle cycle produces no pulse
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!excValid && !redirectValid));

endmodule

bind deferred_tag_rf dtag_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) i_dtag_checker (
  .clk           (clk),
  .rstN          (rstN),
  .opValid       (opValid),
  .opKind        (opKind),
  .opData        (opData),
  .loadFault     (loadFault),
  .rdAddr        (rdAddr),
  .rdData        (rdData),
  .rdTag         (rdTag),
  .excValid      (excValid),
  .redirectValid (redirectValid),
  .redirectTarget(redirectTarget),
  .srcTagA       (srcTagA)
);

// File: tb/test_deferred_tag_rf.sv
`timescale 1ns/1ps
module test_deferred_tag_rf;

  localparam int DATA_W   = 64;
  localparam int NUM_REGS = 32;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [2:0]        opKind = 3'd0;
  logic [ADDR_W-1:0] opDest = '0, opSrcA = '0, opSrcB = '0;
  logic [DATA_W-1:0] opData = '0;
  logic              loadFault = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdTag, excValid, redirectValid;
  logic [DATA_W-1:0] redirectTarget;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  deferred_tag_rf #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) i_deferred_tag_rf (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opDest(opDest), .opSrcA(opSrcA), .opSrcB(opSrcB), .opData(opData),
    .loadFault(loadFault), .rdAddr(rdAddr), .rdData(rdData), .rdTag(rdTag),
    .excValid(excValid), .redirectValid(redirectValid),
    .redirectTarget(redirectTarget)
  );

  typedef struct packed {
    logic [2:0]        kind;
    logic [ADDR_W-1:0] dest;
    logic [ADDR_W-1:0] srcA;
    logic [ADDR_W-1:0] srcB;
    logic [DATA_W-1:0] data;
    logic              fault;
    logic [ADDR_W-1:0] obs;
    logic [DATA_W-1:0] expData;
    logic              expTag;
    logic              expRedir;
    logic              expExc;
  } vec_t;

  localparam int NV = 16;
  // kind, dest, srcA, srcB, data, fault, obs, expData, expTag, expRedir, expExc
  localparam vec_t VECS [NV] = '{
    '{3'd5, 5'd1, 5'd0, 5'd0, 64'h10, 1'b0, 5'd1, 64'h10, 1'b0, 1'b0, 1'b0},
    '{3'd1, 5'd2, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 5'd2,
      64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1'b0, 1'b0},
    '{3'd2, 5'd3, 5'd0, 5'd0, 64'h1234, 1'b1, 5'd3, 64'h0, 1'b1, 1'b0, 1'b0},
    '{3'd3, 5'd4, 5'd1, 5'd2, 64'h0, 1'b0, 5'd4, 64'h0, 1'b0, 1'b0, 1'b0},
    '{3'd3, 5'd5, 5'd3, 5'd1, 64'h0, 1'b0, 5'd5, 64'h10, 1'b1, 1'b0, 1'b0},
    '{3'd4, 5'd0, 5'd5, 5'd0, 64'hDEAD_BEEF_0000_0100, 1'b0, 5'd5, 64'h10, 1'b1, 1'b1, 1'b0},
    '{3'd4, 5'd0, 5'd1, 5'd0, 64'h200, 1'b0, 5'd1, 64'h10, 1'b0, 1'b0, 1'b0},
    '{3'd1, 5'd1, 5'd0, 5'd0, 64'h99, 1'b1, 5'd1, 64'h10, 1'b0, 1'b0, 1'b1},
    '{3'd2, 5'd5, 5'd0, 5'd0, 64'h77, 1'b0, 5'd5, 64'h77, 1'b0, 1'b0, 1'b0},
    '{3'd4, 5'd0, 5'd5, 5'd0, 64'h300, 1'b0, 5'd5, 64'h77, 1'b0, 1'b0, 1'b0},
    '{3'd5, 5'd0, 5'd0, 5'd0, 64'h55, 1'b0, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0},
    '{3'd2, 5'd0, 5'd0, 5'd0, 64'h66, 1'b1, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0},
    '{3'd4, 5'd0, 5'd0, 5'd0, 64'h400, 1'b0, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0},
    '{3'd2, 5'd6, 5'd0, 5'd0, 64'hABC, 1'b1, 5'd6, 64'h0, 1'b1, 1'b0, 1'b0},
    '{3'd5, 5'd6, 5'd0, 5'd0, 64'h5, 1'b0, 5'd6, 64'h5, 1'b0, 1'b0, 1'b0},
    '{3'd3, 5'd7, 5'd6, 5'd3, 64'h0, 1'b0, 5'd7, 64'h5, 1'b1, 1'b0, 1'b0}
  };
  string vReq [NV] = '{"R2", "R2", "R3", "R6", "R6", "R7", "R8", "R5",
                       "R4", "R8", "R9", "R9", "R9", "R3", "R2", "R6"};

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // present one operation to exactly one rising edge, then go idle
  task automatic doOp(input logic valid, input logic [2:0] kind,
                      input logic [ADDR_W-1:0] dest, input logic [ADDR_W-1:0] srcA,
                      input logic [ADDR_W-1:0] srcB, input logic [DATA_W-1:0] data,
                      input logic fault);
    @(negedge clk);
    opValid = valid; opKind = kind; opDest = dest; opSrcA = srcA;
    opSrcB = srcB; opData = data; loadFault = fault;
    @(posedge clk);
    #2;
    opValid = 1'b0; opKind = 3'd0; loadFault = 1'b0;
  endtask

  task automatic observe(input logic [ADDR_W-1:0] addr);
    rdAddr = addr;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;
    @(negedge clk);

    // R1: reset state of every register and of both pulses
    begin
      int bad = 0;
      for (int r = 0; r < NUM_REGS; r++) begin
        observe(ADDR_W'(r));
        if (rdData !== '0 || rdTag !== 1'b0) bad++;
      end
      check("R1", "registers not clean after reset", 64'(bad), 64'd0);
    end
    check("R1", "excValid after reset", 64'(excValid), 64'd0);
    check("R1", "redirectValid after reset", 64'(redirectValid), 64'd0);

    // table of operations
    for (int i = 0; i < NV; i++) begin
      doOp(1'b1, VECS[i].kind, VECS[i].dest, VECS[i].srcA, VECS[i].srcB,
           VECS[i].data, VECS[i].fault);
      observe(VECS[i].obs);
      check(vReq[i], $sformatf("vector %0d data", i), rdData, VECS[i].expData);
      check(vReq[i], $sformatf("vector %0d tag", i), 64'(rdTag), 64'(VECS[i].expTag));
      check(vReq[i], $sformatf("vector %0d redirect", i), 64'(redirectValid),
            64'(VECS[i].expRedir));
      check(vReq[i], $sformatf("vector %0d exception", i), 64'(excValid),
            64'(VECS[i].expExc));
      if (VECS[i].expRedir)
        check(vReq[i], $sformatf("vector %0d target", i), redirectTarget, VECS[i].data);
    end

    // R7: poisoned r7 redirects for one cycle only
    doOp(1'b1, 3'd4, 5'd0, 5'd7, 5'd0, 64'h0000_0000_0000_1000, 1'b0);
    observe(5'd7);
    check("R7", "redirect on poisoned r7", 64'(redirectValid), 64'd1);
    check("R7", "redirect target", redirectTarget, 64'h1000);
    check("R7", "check leaves r7 data", rdData, 64'h5);
    doOp(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 64'h0, 1'b0);
    check("R7", "redirect pulse width", 64'(redirectValid), 64'd0);

    // R5: exception pulse lasts one cycle
    doOp(1'b1, 3'd1, 5'd2, 5'd0, 5'd0, 64'h1, 1'b1);
    check("R5", "exception pulse", 64'(excValid), 64'd1);
    doOp(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 64'h0, 1'b0);
    check("R5", "exception pulse width", 64'(excValid), 64'd0);
    observe(5'd2);
    check("R5", "faulting load keeps r2", rdData, 64'hFFFF_FFFF_FFFF_FFF0);

    // R10: operations with opValid low have no effect
    doOp(1'b0, 3'd5, 5'd1, 5'd0, 5'd0, 64'hBAD, 1'b0);
    observe(5'd1);
    check("R10", "idle move leaves r1", rdData, 64'h10);
    doOp(1'b0, 3'd2, 5'd1, 5'd0, 5'd0, 64'hBAD, 1'b1);
    check("R10", "idle spec load leaves r1 tag", 64'(rdTag), 64'd0);
    doOp(1'b0, 3'd4, 5'd0, 5'd7, 5'd0, 64'h2000, 1'b0);
    check("R10", "idle check on poisoned r7", 64'(redirectValid), 64'd0);
    doOp(1'b0, 3'd1, 5'd1, 5'd0, 5'd0, 64'h0, 1'b1);
    check("R10", "idle faulting load", 64'(excValid), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule